// File: doc/BRIEF.md
# Exception-Return Status Update Unit

This unit computes the processor state that results from the two return-from-trap instructions: the ordinary return from exception and the return from non-maskable interrupt. The status register keeps a small stack of nested flag groups. A return pops that stack by shifting the low field of the status word right by a fixed amount, and the two topmost bits stay where they are. After the pop, flags are forced according to the command. If the popped state says the processor is going back to user mode, the stack pointers are swapped.

A command is a two-bit one-hot vector, sampled on a rising clock edge together with the current status word, the current stack pointer and the saved user stack pointer. The new status word, the new stack pointer and the saved kernel stack pointer are registered. They appear on the outputs one clock after the command and hold there until the next command.

Top module: `xret_status_unit`

## Requirements
- R1: One clock after a command, `stat_out[31:30]` equals `stat_in[31:30]` as sampled with the command.
- R2: One clock after a command, `stat_out[17:0]` equals `stat_in[27:10]`, except where R4 or R5 forces bit 7 or bit 10 to one.
- R3: One clock after a command, `stat_out[29:18]` is zero.
- R4: For either command, bit 7 of the result is forced to one when `stat_in[8]` is zero. When `stat_in[8]` is one, result bit 7 is `stat_in[17]`.
- R5: For the NMI return (`cmd = 2'b10`), result bit 10 is always one. For the exception return (`cmd = 2'b01`), result bit 10 is `stat_in[20]`.
- R6: When result bit 6, the user-mode flag (taken from `stat_in[16]`), is one after a command, `ksp_out` becomes `sp_in` and `sp_out` becomes `usp_in`.
- R7: When result bit 6 is zero after a command, `sp_out` becomes `sp_in` and `ksp_out` keeps its previous value.
- R8: A clock with `cmd = 2'b00` leaves all three outputs unchanged, whatever the other inputs are.
- R9: A synchronous active-high reset clears all three outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 2 | One-hot command: bit 0 exception return, bit 1 NMI return |
| stat_in | input | 32 | Current status word |
| sp_in | input | 32 | Current stack pointer |
| usp_in | input | 32 | Saved user stack pointer |
| stat_out | output | 32 | Updated status word |
| sp_out | output | 32 | Updated stack pointer |
| ksp_out | output | 32 | Saved kernel stack pointer |

## Verification
The forced P flag and the user-mode stack swap can land on the same clock. So can the forced P flag and the forced M flag of an NMI return. Both cases are provoked with status words that have bit 8 clear and bit 16 set, sent with each command in turn. The whole registered result (status, stack pointer, kernel stack pointer) is compared in one go against an independent model, so a fault in one of the coincident updates cannot be hidden by a correct value in another.

// File: rtl/xret_pkg.sv
package xret_pkg;

    localparam int WORD_W  = 32;
    localparam int KEEP_W  = 2;
    localparam int FIELD_W = 28;
    localparam int SHIFT   = 10;
    localparam int U_POS   = 6;
    localparam int P_POS   = 7;
    localparam int R_POS   = 8;
    localparam int M_POS   = 10;

    localparam logic [WORD_W-1:0] FIELD_MASK = (WORD_W'(1) << FIELD_W) - WORD_W'(1);
    localparam logic [WORD_W-1:0] KEEP_MASK  = ~((WORD_W'(1) << (WORD_W - KEEP_W)) - WORD_W'(1));

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_RFE  = 2'b01,
        OP_RFN  = 2'b10
    } ret_op_e;

    typedef struct packed {
        word_t stat;
        word_t sp;
        word_t ksp;
    } ret_state_t;

    function automatic word_t pop_flags(input word_t s);
        return (s & KEEP_MASK) | ((s & FIELD_MASK) >> SHIFT);
    endfunction

endpackage

// File: rtl/xret_cmd_dec.sv
module xret_cmd_dec
    import xret_pkg::*;
(
    input  logic [1:0] cmd,
    output ret_op_e    op,
    output logic       active
);
    always_comb begin
        unique case (cmd)
            2'b01:   op = OP_RFE;
            2'b10:   op = OP_RFN;
            default: op = OP_NONE;
        endcase
        active = (op != OP_NONE);
    end
endmodule

// File: rtl/xret_stat_calc.sv
module xret_stat_calc
    import xret_pkg::*;
(
    input  ret_op_e op,
    input  word_t   stat_in,
    output word_t   stat_nx,
    output logic    user_nx
);
    word_t popped;
    logic  set_p;
    logic  set_m;

    always_comb begin
        popped = pop_flags(stat_in);
        set_p  = ~stat_in[R_POS];
        set_m  = (op == OP_RFN);
    end

    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        if (i == P_POS) begin : g_p
            assign stat_nx[i] = popped[i] | set_p;
        end else if (i == M_POS) begin : g_m
            assign stat_nx[i] = popped[i] | set_m;
        end else begin : g_pass
            assign stat_nx[i] = popped[i];
        end
    end

    assign user_nx = stat_nx[U_POS];
endmodule

// File: rtl/xret_stack_sel.sv
module xret_stack_sel
    import xret_pkg::*;
(
    input  logic  user_nx,
    input  word_t sp_in,
    input  word_t usp_in,
    input  word_t ksp_q,
    output word_t sp_nx,
    output word_t ksp_nx
);
    always_comb begin
        if (user_nx) begin
            sp_nx  = usp_in;
            ksp_nx = sp_in;
        end else begin
            sp_nx  = sp_in;
            ksp_nx = ksp_q;
        end
    end
endmodule

// File: rtl/xret_status_unit.sv
module xret_status_unit
    import xret_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  cmd,
    input  logic [31:0] stat_in,
    input  logic [31:0] sp_in,
    input  logic [31:0] usp_in,
    output logic [31:0] stat_out,
    output logic [31:0] sp_out,
    output logic [31:0] ksp_out
);
    ret_op_e    op;
    logic       active;
    logic       user_nx;
    ret_state_t st_q;
    ret_state_t st_d;

    xret_cmd_dec u_dec (
        .cmd    (cmd),
        .op     (op),
        .active (active)
    );

    xret_stat_calc u_calc (
        .op      (op),
        .stat_in (stat_in),
        .stat_nx (st_d.stat),
        .user_nx (user_nx)
    );

    xret_stack_sel u_stk (
        .user_nx (user_nx),
        .sp_in   (sp_in),
        .usp_in  (usp_in),
        .ksp_q   (st_q.ksp),
        .sp_nx   (st_d.sp),
        .ksp_nx  (st_d.ksp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (active) begin
            st_q <= st_d;
        end
    end

    assign stat_out = st_q.stat;
    assign sp_out   = st_q.sp;
    assign ksp_out  = st_q.ksp;
endmodule

// File: rtl/xret_status_chk.sv
module xret_status_chk (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  cmd,
    input logic [31:0] stat_in,
    input logic [31:0] sp_in,
    input logic [31:0] usp_in,
    input logic [31:0] stat_out,
    input logic [31:0] sp_out,
    input logic [31:0] ksp_out
);
    logic go;
    assign go = (cmd == 2'b01) || (cmd == 2'b10);

    assert_cmd_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd));

    assert_top_kept_R1: assert property (@(posedge clk) disable iff (rst)
        go |=> stat_out[31:30] == $past(stat_in[31:30]));

    assert_gap_zero_R3: assert property (@(posedge clk) disable iff (rst)
        go |=> stat_out[29:18] == 12'h000);

    assert_low_shift_R2: assert property (@(posedge clk) disable iff (rst)
        go |=> stat_out[6:0] == $past(stat_in[16:10]));

    assert_p_forced_R4: assert property (@(posedge clk) disable iff (rst)
        (go && !stat_in[8]) |=> stat_out[7]);

    assert_p_popped_R4: assert property (@(posedge clk) disable iff (rst)
        (go && stat_in[8]) |=> stat_out[7] == $past(stat_in[17]));

    assert_m_forced_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd == 2'b10) |=> stat_out[10]);

    assert_m_popped_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd == 2'b01) |=> stat_out[10] == $past(stat_in[20]));

    assert_swap_R6: assert property (@(posedge clk) disable iff (rst)
        (go && stat_in[16]) |=> (sp_out == $past(usp_in)) && (ksp_out == $past(sp_in)));

    assert_noswap_R7: assert property (@(posedge clk) disable iff (rst)
        (go && !stat_in[16]) |=> (sp_out == $past(sp_in)) && $stable(ksp_out));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd == 2'b00) |=> $stable(stat_out) && $stable(sp_out) && $stable(ksp_out));

    assert_reset_R9: assert property (@(posedge clk)
        rst |=> (stat_out == 32'h0) && (sp_out == 32'h0) && (ksp_out == 32'h0));
endmodule

bind xret_status_unit xret_status_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .stat_in  (stat_in),
    .sp_in    (sp_in),
    .usp_in   (usp_in),
    .stat_out (stat_out),
    .sp_out   (sp_out),
    .ksp_out  (ksp_out)
);

// File: tb/xret_status_unit_test.sv
`timescale 1ns/1ps
module xret_status_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cmd = 2'b00;
    logic [31:0] stat_in = '0;
    logic [31:0] sp_in = '0;
    logic [31:0] usp_in = '0;
    logic [31:0] stat_out, sp_out, ksp_out;

    always #4 clk = ~clk;

    xret_status_unit uut (
        .clk(clk), .rst(rst), .cmd(cmd), .stat_in(stat_in),
        .sp_in(sp_in), .usp_in(usp_in),
        .stat_out(stat_out), .sp_out(sp_out), .ksp_out(ksp_out)
    );

    typedef struct {
        logic [31:0] stat;
        logic [31:0] sp;
        logic [31:0] ksp;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          vectors = 0;
    int          miscompares = 0;
    logic [31:0] m_stat = '0, m_sp = '0, m_ksp = '0;
    bit          done = 0;

    task automatic apply(input logic [1:0] c, input logic [31:0] s,
                         input logic [31:0] p, input logic [31:0] u, input string tag);
        exp_t e;
        logic [31:0] r;
        @(negedge clk);
        cmd = c; stat_in = s; sp_in = p; usp_in = u;
        if (c != 2'b00) begin
            r = {s[31:30], 12'h000, s[27:10]};
            if (!s[8]) r[7] = 1'b1;
            if (c == 2'b10) r[10] = 1'b1;
            m_stat = r;
            if (r[6]) begin m_ksp = p; m_sp = u; end
            else m_sp = p;
        end
        e.stat = m_stat; e.sp = m_sp; e.ksp = m_ksp; e.tag = tag;
        sb.push_back(e);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() != 0) begin
                e = sb.pop_front();
                vectors++;
                if (stat_out !== e.stat || sp_out !== e.sp || ksp_out !== e.ksp) begin
                    miscompares++;
                    $display("FAIL %s: got stat=%h sp=%h ksp=%h expected stat=%h sp=%h ksp=%h",
                             e.tag, stat_out, sp_out, ksp_out, e.stat, e.sp, e.ksp);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state checked with an idle vector while reset is still high
        cmd = 2'b00;
        sb.push_back('{stat: 32'h0, sp: 32'h0, ksp: 32'h0, tag: "R9 reset"});
        @(negedge clk);
        rst = 1'b0;
        // R1 R2 R3 R4: R clear forces P
        apply(2'b01, 32'hC000_0000, 32'h1111_0000, 32'h2222_0000, "R4 p-forced rfe");
        apply(2'b01, 32'h0002_0100, 32'h1111_0004, 32'h2222_0004, "R4 p-from-bit17");
        apply(2'b01, 32'h0000_0100, 32'h1111_0008, 32'h2222_0008, "R4 p-clear");
        apply(2'b10, 32'h0000_0100, 32'h1111_000C, 32'h2222_000C, "R5 m-forced rfn");
        apply(2'b01, 32'h0000_0100, 32'h1111_0010, 32'h2222_0010, "R5 m-clear rfe");
        apply(2'b01, 32'h0010_0100, 32'h1111_0014, 32'h2222_0014, "R5 m-from-bit20");
        apply(2'b01, 32'hFFFF_FFFF, 32'h3333_0000, 32'h4444_0000, "R1 R3 all-ones swap");
        apply(2'b01, 32'h5555_AAAA, 32'h3333_0004, 32'h4444_0004, "R2 pattern");
        // R6 with P coincident
        apply(2'b01, 32'h0001_0000, 32'hAAAA_0000, 32'hBBBB_0000, "R6 swap plus p rfe");
        apply(2'b10, 32'h0001_0000, 32'hAAAA_0010, 32'hBBBB_0010, "R6 swap plus p plus m rfn");
        // R7 ksp must hold after swap above
        apply(2'b10, 32'h0000_0000, 32'hCCCC_0000, 32'hDDDD_0000, "R7 no swap");
        // R8 idle with wild inputs
        apply(2'b00, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 32'hFEED_FACE, "R8 idle hold");
        apply(2'b00, 32'h0001_0000, 32'h0BAD_0000, 32'h0BAD_0001, "R8 idle hold 2");
        for (int i = 0; i < 60; i++) begin
            logic [1:0] c;
            c = (i % 3 == 0) ? 2'b00 : ((i % 3 == 1) ? 2'b01 : 2'b10);
            apply(c, $urandom(), $urandom(), $urandom(), "R2 R6 R7 R8 mixed");
        end
        @(negedge clk);
        cmd = 2'b00;
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule